// File: doc/BRIEF.md
# Digital Monostable Pulse Generator

A clock-synchronous one-shot. A qualifying trigger edge produces a single high pulse on `q_o`, and `qn_o` carries its complement. The pulse length is a number of clock cycles given on `width_i`, in place of a resistor-capacitor time constant. The length is the same whether the trigger input is held for one cycle or for many.

There are two active-low trigger pins (`a1n_i`, `a2n_i`) and two active-high trigger pins (`b1_i`, `b2_i`). The low side is asserted when either of its pins is low. The high side is asserted only when both of its pins are high. The two sides are combined with AND into one trigger term, and a pulse starts when that term goes from inactive to active. An active-low clear kills any pulse.

Two parameters set the variant:
- `RETRIG` selects whether a trigger during a pulse restarts the timing.
- `CLR_TRIG` selects whether releasing clear, while the trigger term is already active, starts a pulse.

All five control pins pass through a two-stage synchronizer before any edge is detected.

Top module: `digital_one_shot`

## Requirements
- R1: While `rst_ni` is low and after its release with no trigger, `q_o` is 0 and `qn_o` is 1.
- R2: `qn_o` is always the inverse of `q_o`.
- R3: With both B pins high, a fall of either A pin (the other A pin high) starts a pulse. `q_o` is first high at the third rising clock edge after the pin change.
- R4: With at least one A pin low and one B pin already high, a rise of the other B pin starts a pulse.
- R5: `q_o` stays high for exactly `width_i` clock cycles, whatever the duration of the trigger. A `width_i` of 0 gives a 1-cycle pulse.
- R6: No pulse starts while both A pins are high or while either B pin is low, whatever the other pins do.
- R7: `clr_ni` low ends a running pulse, with `q_o` low from the third rising edge after the fall. No trigger starts a pulse while clear is low.
- R8: With `CLR_TRIG=0`, releasing `clr_ni` never starts a pulse, even when the trigger term is active.
- R9: With `CLR_TRIG=1`, a rise of `clr_ni` while the trigger term has been active for at least one synchronized cycle starts a full pulse.
- R10: A trigger edge and a clear release seen in the same synchronized cycle start no pulse, in either mode.
- R11: With `RETRIG=1`, a trigger during a pulse reloads the count, so `q_o` falls `width_i` cycles after the last trigger takes effect.
- R12: With `RETRIG=0`, triggers that arrive while `q_o` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a1n_i | input | 1 | Trigger pin, active low |
| a2n_i | input | 1 | Trigger pin, active low |
| b1_i | input | 1 | Trigger pin, active high |
| b2_i | input | 1 | Trigger pin, active high |
| clr_ni | input | 1 | Clear, active low |
| width_i | input | CNT_W | Pulse length in clock cycles |
| q_o | output | 1 | Pulse output |
| qn_o | output | 1 | Complement of `q_o` |

## Verification
The hardest situations to reach from the pins are the ones that hinge on the ordering of clear against the trigger term. These are:
- a clear release while the term is already active;
- a clear release in the very same synchronized cycle as a term edge.

The bench holds clear low while it sets up the trigger pins. For the first case it lets the term settle before releasing clear. For the second it raises clear and the last B pin on the same clock phase, so both pass the synchronizer together.

Two instances share every stimulus, one retriggerable without clear triggering and one the reverse. Each retrigger and clear scenario therefore shows both outcomes in the same run.

// File: rtl/os_pkg.sv
package os_pkg;
  typedef struct packed {
    logic clr_n;
    logic b2;
    logic b1;
    logic a2n;
    logic a1n;
  } os_pins_t;

  // idle pin levels seen while in reset: clear asserted, no trigger
  localparam os_pins_t PINS_RST = '{clr_n: 1'b0, b2: 1'b0, b1: 1'b0, a2n: 1'b1, a1n: 1'b1};
endpackage

// File: rtl/os_sync.sv
module os_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] nxt;
    if (s == 0) begin : g_first
      assign nxt = d_i;
    end else begin : g_next
      assign nxt = stg_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else         stg_q[s] <= nxt;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/os_trig.sv
module os_trig #(
  parameter bit CLR_TRIG = 1'b0
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  os_pkg::os_pins_t pins_i,
  output logic           fire_o
);
  logic term, term_q, clr_q, edge_fire, clr_fire;

  // low side: any A low; high side: all B high
  assign term = ~(pins_i.a1n & pins_i.a2n) & pins_i.b1 & pins_i.b2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      term_q <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      term_q <= term;
      clr_q  <= pins_i.clr_n;
    end
  end

  // clear must be high now and a cycle earlier; a tie with release goes to clear
  assign edge_fire = term & ~term_q & pins_i.clr_n & clr_q;

  if (CLR_TRIG) begin : g_clr_trig
    assign clr_fire = pins_i.clr_n & ~clr_q & term & term_q;
  end else begin : g_no_clr_trig
    assign clr_fire = 1'b0;
  end

  assign fire_o = edge_fire | clr_fire;

  // R8
  no_clr_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!CLR_TRIG && pins_i.clr_n && !clr_q) |-> !fire_o);

  // R10
  tie_to_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins_i.clr_n && !clr_q && term && !term_q) |-> !fire_o);
endmodule

// File: rtl/os_timer.sv
module os_timer #(
  parameter int unsigned CNT_W  = 16,
  parameter bit          RETRIG = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             busy_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, wid_eff;
  logic busy, load;

  assign busy    = (cnt_q != '0);
  assign wid_eff = (width_i == '0) ? ONE : width_i;
  assign load    = start_i && (RETRIG || !busy);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!clr_i)  cnt_q <= '0;
    else if (load)    cnt_q <= wid_eff;
    else if (busy)    cnt_q <= cnt_q - ONE;
  end

  assign busy_o = busy;

  // R7
  clear_kill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_q == '0));

  // R5
  count_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && clr_i && !start_i) |=> (cnt_q == $past(cnt_q) - ONE));

  // R12
  no_retrig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!RETRIG && busy && clr_i) |=> (cnt_q == $past(cnt_q) - ONE));
endmodule

// File: rtl/digital_one_shot.sv
module digital_one_shot #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          RETRIG      = 1'b1,
  parameter bit          CLR_TRIG    = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a1n_i,
  input  logic             a2n_i,
  input  logic             b1_i,
  input  logic             b2_i,
  input  logic             clr_ni,
  input  logic [CNT_W-1:0] width_i,
  output logic             q_o,
  output logic             qn_o
);
  import os_pkg::*;

  os_pins_t raw, syn;
  logic fire, busy;

  assign raw.clr_n = clr_ni;
  assign raw.b2    = b2_i;
  assign raw.b1    = b1_i;
  assign raw.a2n   = a2n_i;
  assign raw.a1n   = a1n_i;

  os_sync #(
    .W      ($bits(os_pins_t)),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PINS_RST)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  os_trig #(.CLR_TRIG(CLR_TRIG)) u_trig (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pins_i(syn),
    .fire_o(fire)
  );

  os_timer #(.CNT_W(CNT_W), .RETRIG(RETRIG)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(fire),
    .clr_i  (syn.clr_n),
    .width_i(width_i),
    .busy_o (busy)
  );

  assign q_o  = busy;
  assign qn_o = ~busy;

  // R3
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !q_o) |=> q_o);
endmodule

// File: tb/sim_digital_one_shot.sv
`timescale 1ns/1ps
module sim_digital_one_shot;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a1n = 1'b1, a2n = 1'b1, b1 = 1'b0, b2 = 1'b0, clr_n = 1'b1;
  logic [CW-1:0] width = CW'(4);
  logic q0, qn0, q1, qn1;

  int tests = 0, fails = 0;
  int hi0 = 0, hi1 = 0, comp_err = 0;
  bit cnt_en = 1'b0, wd = 1'b0;

  always #5 clk = ~clk;

  digital_one_shot #(.CNT_W(CW), .RETRIG(1'b1), .CLR_TRIG(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .a1n_i(a1n), .a2n_i(a2n), .b1_i(b1), .b2_i(b2),
    .clr_ni(clr_n), .width_i(width), .q_o(q0), .qn_o(qn0));

  digital_one_shot #(.CNT_W(CW), .RETRIG(1'b0), .CLR_TRIG(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .a1n_i(a1n), .a2n_i(a2n), .b1_i(b1), .b2_i(b2),
    .clr_ni(clr_n), .width_i(width), .q_o(q1), .qn_o(qn1));

  always @(negedge clk) begin
    if (cnt_en) begin
      hi0 += int'(q0);
      hi1 += int'(q1);
    end
    if (qn0 !== ~q0 || qn1 !== ~q1) comp_err++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    a1n = 1'b1; a2n = 1'b1; b1 = 1'b0; b2 = 1'b0; clr_n = 1'b1;
    tick(30);
    cnt_en = 1'b0; hi0 = 0; hi1 = 0;
  endtask

  task automatic start_count();
    hi0 = 0; hi1 = 0; cnt_en = 1'b1;
  endtask

  task automatic t_reset();
    tick(3);
    chk(q0 == 1'b0 && qn0 == 1'b1, "R1 u0 in reset", int'(q0), 0);
    chk(q1 == 1'b0 && qn1 == 1'b1, "R1 u1 in reset", int'(q1), 0);
    rst_n = 1'b1;
    tick(5);
    chk(q0 == 1'b0 && q1 == 1'b0, "R1 after release", int'(q0 | q1), 0);
  endtask

  task automatic t_a_fall();
    width = CW'(6);
    b1 = 1'b1; b2 = 1'b1;
    tick(5);
    start_count();
    a2n = 1'b0;
    tick(2);
    chk(q0 == 1'b0, "R3 latency two edges", int'(q0), 0);
    tick(1);
    chk(q0 == 1'b1 && q1 == 1'b1, "R3 high at third edge", int'(q0 & q1), 1);
    tick(30);
    chk(hi0 == 6, "R3 u0 width", hi0, 6);
    chk(hi1 == 6, "R3 u1 width", hi1, 6);
    idle();
  endtask

  task automatic t_b_rise();
    width = CW'(4);
    a1n = 1'b0; b1 = 1'b1;
    tick(5);
    start_count();
    b2 = 1'b1;
    tick(3);
    chk(q0 == 1'b1, "R4 B rise starts pulse", int'(q0), 1);
    tick(30);
    chk(hi0 == 4 && hi1 == 4, "R4 width", hi0, 4);
    idle();
  endtask

  task automatic t_no_trig();
    width = CW'(4);
    start_count();
    b1 = 1'b1;
    tick(2);
    a1n = 1'b0;
    tick(5);
    a1n = 1'b1;
    a2n = 1'b0;
    tick(5);
    a2n = 1'b1;
    tick(2);
    b2 = 1'b1;
    tick(5);
    b1 = 1'b0;
    tick(10);
    chk(hi0 == 0, "R6 u0 no pulse", hi0, 0);
    chk(hi1 == 0, "R6 u1 no pulse", hi1, 0);
    idle();
  endtask

  task automatic one_width(input int w, input int hold, input int exp, input string tag);
    width = CW'(w);
    b1 = 1'b1; b2 = 1'b1;
    tick(5);
    start_count();
    a1n = 1'b0;
    tick(hold);
    a1n = 1'b1;
    tick(30);
    chk(hi0 == exp && hi1 == exp, tag, hi0, exp);
    idle();
  endtask

  task automatic t_width();
    one_width(0, 1, 1, "R5 zero width");
    one_width(1, 1, 1, "R5 width one");
    one_width(5, 40, 5, "R5 long hold");
    one_width(9, 2, 9, "R5 short hold");
  endtask

  task automatic t_retrig();
    width = CW'(8);
    b1 = 1'b1; b2 = 1'b1;
    tick(5);
    start_count();
    a1n = 1'b0;
    tick(4);
    a1n = 1'b1;
    tick(1);
    a1n = 1'b0;
    tick(40);
    chk(hi0 == 13, "R11 retrigger extends", hi0, 13);
    chk(hi1 == 8, "R12 retrigger ignored", hi1, 8);
    idle();
  endtask

  task automatic t_clear();
    width = CW'(20);
    b1 = 1'b1; b2 = 1'b1;
    tick(5);
    start_count();
    a1n = 1'b0;
    tick(5);
    clr_n = 1'b0;
    tick(2);
    chk(q0 == 1'b1, "R7 clear latency", int'(q0), 1);
    tick(1);
    chk(q0 == 1'b0 && q1 == 1'b0, "R7 clear ends pulse", int'(q0 | q1), 0);
    a1n = 1'b1;
    tick(2);
    a1n = 1'b0;
    tick(6);
    chk(hi0 == 5 && hi1 == 5, "R7 no trigger under clear", hi0, 5);
    start_count();
    clr_n = 1'b1;
    tick(40);
    chk(hi0 == 0, "R8 release gives no pulse", hi0, 0);
    chk(hi1 == 20, "R9 release triggers", hi1, 20);
    idle();
  endtask

  task automatic t_tie();
    width = CW'(6);
    clr_n = 1'b0;
    a1n = 1'b0; b1 = 1'b1;
    tick(6);
    start_count();
    clr_n = 1'b1;
    b2 = 1'b1;
    tick(30);
    chk(hi0 == 0, "R10 u0 tie to clear", hi0, 0);
    chk(hi1 == 0, "R10 u1 tie to clear", hi1, 0);
    idle();
  endtask

  task automatic run_all();
    t_reset();
    t_a_fall();
    t_b_rise();
    t_no_trig();
    t_width();
    t_retrig();
    t_clear();
    t_tie();
    chk(comp_err == 0, "R2 complement", comp_err, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) chk(1'b0, "watchdog", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule